// File: doc/BRIEF.md
# Programmable Clock-Glitch and Control-Edge Generator

This block derives a test clock from a fast oversampling clock. Every timing quantity is a count of fast-clock ticks. In normal operation each output clock period is a window of `nom_period` ticks: low for the first half and high from the midpoint on, so there is exactly one rising edge per window. A fault-injection experiment arms the block. After a programmed number of windows, one window is replaced by a glitch window. In that window the midpoint rise is followed by two short pulses of period `pulse_period`. Two pulses are used because one very short pulse may be lost.

`pulse_period` is a run-time input. A campaign sweeps it from one arm to the next to find the pulse width that corrupts the target. In the same glitch window the block drives a control output from its idle level to its active level at a programmable tick offset inside the window. This places a control edge just before, on, or just after the active clock edge. After the glitch window the block raises `done` and goes back to plain clocking until it is armed again.

All outputs leave the block straight from flip-flops. `nom_period` may only change while reset is applied. The other configuration inputs must be held from arm until `done`.

Top module: `glitch_clock_gen`

## Requirements
- R1: With no glitch in progress, every window of P = `nom_period` ticks has one rising edge of `clk_out`, at tick P/2 (integer halving) of the window. Consecutive rises are P ticks apart, and the clock stays high for P - P/2 ticks.
- R2: In the glitch window, with T = `pulse_period` and h = P/2, `clk_out` rises at ticks h, h+T and h+2T of the window. The first two high phases each last T/2 ticks (integer halving). The clock then stays high until the window ends, which is P-h-2T ticks.
- R3: The glitch window is window number `target_cycle`. Window 0 is the first window that starts after the window in which arm was taken. Every window before and after it is nominal.
- R4: Each accepted arm yields exactly one glitch window. `done` goes high on the last tick of that window, one tick before `clk_out` falls, and it stays high until the next accepted arm. An accepted arm clears `done` on the following tick.
- R5: `ctl_out` is 1 after reset and after an accepted arm. It falls once, at tick `ctl_offset` of the glitch window, which is `ctl_offset` - P/2 ticks relative to the window's first rise. It then stays 0 until the next accepted arm.
- R6: An arm is accepted only if T >= 2, P/2 + 2*T < P and `ctl_offset` < P. Otherwise it is ignored: no glitch occurs and `done` and `ctl_out` keep their values.
- R7: An arm pulse that arrives while a glitch is already pending or in progress is ignored and does not restart the window count.
- R8: While reset is applied, `clk_out` is 0, `ctl_out` is 1 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Oversampling clock; one tick is the timing unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| nom_period | input | CNT_W | Window length P in ticks |
| pulse_period | input | CNT_W | Short-pulse period T in ticks |
| target_cycle | input | CYC_W | Index of the window to glitch, counted after arm |
| ctl_offset | input | CNT_W | Tick within the glitch window at which the control edge occurs |
| arm | input | 1 | Request one glitch; sampled on the fast clock |
| clk_out | output | 1 | Generated test clock |
| ctl_out | output | 1 | Control signal, idle 1, falls once per accepted arm |
| done | output | 1 | High after the glitch window until the next accepted arm |

## Verification
Two cases are hard to reach from the ports because they need precise placement.

The first is a repeat arm that lands while a glitch is pending. The bench produces it with a long target: it waits for the second window after the first arm and pulses arm again in the middle of that window. It then checks that the glitch still appears at the original window index.

The second is the set of legality boundaries. The bench uses a period where P/2 + 2T equals P exactly, which must be rejected, and a period one tick longer, whose final high phase is a single tick.

Control-edge placement is checked with offsets before, on and after the midpoint. Edge times are measured against the recorded rise times of `clk_out`.

// File: rtl/gcg_pkg.sv
`timescale 1ns/1ps
package gcg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_FIRE  = 2'd2
   } gcg_state_e;

endpackage

// File: rtl/gcg_window_timer.sv
`timescale 1ns/1ps
// Tick counter spanning one output clock window.
module gcg_window_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] phase,
   output logic             wrap
);

   logic [CNT_W-1:0] phase_q;

   assign wrap  = (phase_q >= (period - CNT_W'(1)));
   assign phase = phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    phase_q <= '0;
      else if (wrap) phase_q <= '0;
      else           phase_q <= phase_q + CNT_W'(1);
   end

   // R1: with a steady window length the tick index never leaves the window
   assert_phase_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(period) && (period != '0) && $past(phase_q < period)) |-> (phase_q < period));

endmodule

// File: rtl/gcg_sequencer.sv
`timescale 1ns/1ps
// Arm acceptance, window counting and the one-shot glitch flag.
module gcg_sequencer
   import gcg_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int CYC_W    = 16,
   parameter int N_PULSES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             wrap,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] pulse_per,
   input  logic [CNT_W-1:0] ctl_off,
   input  logic [CYC_W-1:0] target,
   output logic             start,
   output logic             glitch,
   output logic             done
);

   localparam int KW = $clog2(N_PULSES + 1);
   localparam int EW = CNT_W + KW + 2;

   gcg_state_e       st_q;
   logic [CYC_W-1:0] cyc_q;
   logic             done_q;
   logic [EW-1:0]    need;
   logic             cfg_ok;

   // the burst must end strictly before the window does
   always_comb begin
      need   = EW'(period >> 1) + EW'(N_PULSES) * EW'(pulse_per);
      cfg_ok = (pulse_per >= CNT_W'(2)) && (need < EW'(period)) && (ctl_off < period);
   end

   assign start  = arm && (st_q == ST_IDLE) && cfg_ok;
   assign glitch = (st_q == ST_FIRE);
   assign done   = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cyc_q  <= '0;
         done_q <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q   <= ST_ARMED;
                  cyc_q  <= '0;
                  done_q <= 1'b0;
               end
            end
            ST_ARMED: begin
               if (wrap) begin
                  if (cyc_q == target) st_q  <= ST_FIRE;
                  else                 cyc_q <= cyc_q + CYC_W'(1);
               end
            end
            ST_FIRE: begin
               if (wrap) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R4: the glitch window ends in idle with done set
   assert_single_glitch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (glitch && wrap) |=> ((st_q == ST_IDLE) && done_q));

   // R4: done holds until an accepted arm
   assert_done_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !start) |=> done_q);

   // R3: the window count never passes the target (target held while armed)
   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_ARMED) && $stable(target)) |-> (cyc_q <= target));

   // R6: an illegal configuration leaves the block idle
   assert_bad_cfg_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !cfg_ok && (st_q == ST_IDLE)) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/gcg_wave_shaper.sv
`timescale 1ns/1ps
// Produces the registered clock and control levels from the window tick.
module gcg_wave_shaper #(
   parameter int CNT_W    = 8,
   parameter int N_PULSES = 2,
   parameter bit CTL_FALL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] phase,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] pulse_per,
   input  logic [CNT_W-1:0] ctl_off,
   input  logic             glitch,
   input  logic             start,
   output logic             clk_out,
   output logic             ctl_out
);

   localparam int   KW       = $clog2(N_PULSES + 1);
   localparam logic IDLE_LVL = CTL_FALL ? 1'b1 : 1'b0;

   logic [CNT_W-1:0] half, th, sub_q, eff_sub;
   logic [KW-1:0]    k_q, eff_k;
   logic             in_burst, level;
   logic             clk_q, ctl_q;

   always_comb begin
      half     = period >> 1;
      th       = pulse_per >> 1;
      eff_sub  = (phase == half) ? '0 : sub_q;
      eff_k    = (phase == half) ? '0 : k_q;
      in_burst = glitch && (phase >= half) && (eff_k < KW'(N_PULSES));
      if (phase < half)  level = 1'b0;
      else if (in_burst) level = (eff_sub < th);
      else               level = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q <= 1'b0;
         sub_q <= '0;
         k_q   <= '0;
      end else begin
         clk_q <= level;
         if (in_burst) begin
            if (eff_sub == (pulse_per - CNT_W'(1))) begin
               sub_q <= '0;
               k_q   <= eff_k + KW'(1);
            end else begin
               sub_q <= eff_sub + CNT_W'(1);
               k_q   <= eff_k;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ctl_q <= IDLE_LVL;
      else if (start)                        ctl_q <= IDLE_LVL;
      else if (glitch && (phase == ctl_off)) ctl_q <= ~IDLE_LVL;
   end

   assign clk_out = clk_q;
   assign ctl_out = ctl_q;

   // R1: outside a glitch window the only rise comes from the midpoint tick
   assert_nominal_rise_mid_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(clk_q) && !$past(glitch)) |-> ($past(phase) == half));

   // R2: the first half of every window is low
   assert_low_first_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase < half) |=> !clk_q);

   // R5: the control output moves away from idle only during the glitch window
   assert_ctl_edge_in_glitch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctl_q != $past(ctl_q)) && !$past(start)) |-> $past(glitch));

endmodule

// File: rtl/glitch_clock_gen.sv
`timescale 1ns/1ps
module glitch_clock_gen #(
   parameter int CNT_W    = 8,
   parameter int CYC_W    = 16,
   parameter int N_PULSES = 2,
   parameter bit CTL_FALL = 1'b1
) (
   input  logic             clk_fast,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] nom_period,
   input  logic [CNT_W-1:0] pulse_period,
   input  logic [CYC_W-1:0] target_cycle,
   input  logic [CNT_W-1:0] ctl_offset,
   input  logic             arm,
   output logic             clk_out,
   output logic             ctl_out,
   output logic             done
);

   generate
      if (CNT_W < 4) begin : g_bad_cnt_w
         $error("CNT_W must be at least 4");
      end
      if (CYC_W < 1) begin : g_bad_cyc_w
         $error("CYC_W must be at least 1");
      end
      if (N_PULSES < 1) begin : g_bad_pulses
         $error("N_PULSES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] phase;
   logic             wrap, start, glitch;

   gcg_window_timer #(.CNT_W(CNT_W)) i_timer (
      .clk    (clk_fast),
      .rst_n  (rst_n),
      .period (nom_period),
      .phase  (phase),
      .wrap   (wrap)
   );

   gcg_sequencer #(.CNT_W(CNT_W), .CYC_W(CYC_W), .N_PULSES(N_PULSES)) i_seq (
      .clk       (clk_fast),
      .rst_n     (rst_n),
      .arm       (arm),
      .wrap      (wrap),
      .period    (nom_period),
      .pulse_per (pulse_period),
      .ctl_off   (ctl_offset),
      .target    (target_cycle),
      .start     (start),
      .glitch    (glitch),
      .done      (done)
   );

   gcg_wave_shaper #(.CNT_W(CNT_W), .N_PULSES(N_PULSES), .CTL_FALL(CTL_FALL)) i_shaper (
      .clk       (clk_fast),
      .rst_n     (rst_n),
      .phase     (phase),
      .period    (nom_period),
      .pulse_per (pulse_period),
      .ctl_off   (ctl_offset),
      .glitch    (glitch),
      .start     (start),
      .clk_out   (clk_out),
      .ctl_out   (ctl_out)
   );

endmodule

// File: tb/test_glitch_clock_gen.sv
`timescale 1ns/1ps
module test_glitch_clock_gen;

   localparam int CW = 8;
   localparam int YW = 16;
   localparam int AM = 2047;

   logic          clk_fast = 1'b0;
   logic          rst_n    = 1'b0;
   logic [CW-1:0] nom_period   = CW'(20);
   logic [CW-1:0] pulse_period = CW'(3);
   logic [YW-1:0] target_cycle = '0;
   logic [CW-1:0] ctl_offset   = '0;
   logic          arm = 1'b0;
   logic          clk_out, ctl_out, done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk_fast = ~clk_fast;   // 250 MHz

   glitch_clock_gen i_glitch_clock_gen (
      .clk_fast     (clk_fast),
      .rst_n        (rst_n),
      .nom_period   (nom_period),
      .pulse_period (pulse_period),
      .target_cycle (target_cycle),
      .ctl_offset   (ctl_offset),
      .arm          (arm),
      .clk_out      (clk_out),
      .ctl_out      (ctl_out),
      .done         (done)
   );

   // edge recorder, sampled 1 ns after each active edge
   int   tick = 0;
   int   n_rise = 0;
   int   rise_t [0:AM];
   int   hw     [0:AM];
   int   ctl_fall_t = -1;
   int   done_t = -1;
   logic prev_c = 1'b0, prev_ctl = 1'b1, prev_done = 1'b0;

   always @(posedge clk_fast) begin
      #1;
      tick++;
      if (clk_out === 1'b1 && prev_c === 1'b0) begin
         rise_t[n_rise & AM] = tick;
         n_rise++;
      end
      if (clk_out === 1'b0 && prev_c === 1'b1 && n_rise > 0)
         hw[(n_rise - 1) & AM] = tick - rise_t[(n_rise - 1) & AM];
      if (ctl_out === 1'b0 && prev_ctl === 1'b1) ctl_fall_t = tick;
      if (done === 1'b1 && prev_done === 1'b0) done_t = tick;
      prev_c    = clk_out;
      prev_ctl  = ctl_out;
      prev_done = done;
   end

   function automatic int rt(int i);
      return rise_t[i & AM];
   endfunction

   function automatic int hwd(int i);
      return hw[i & AM];
   endfunction

   task automatic check_eq(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk_fast);
   endtask

   task automatic wait_rises(int n);
      int lim = 0;
      while (n_rise < n && lim < 5000) begin
         @(negedge clk_fast);
         lim++;
      end
   endtask

   // pulses arm for one tick right after a rise; returns the index of the next rise
   task automatic arm_after_rise(output int base);
      int r = n_rise;
      wait_rises(r + 1);
      base = n_rise;
      arm = 1'b1;
      step(1);
      arm = 1'b0;
   endtask

   task automatic t_reset(int p);
      nom_period = CW'(p);
      rst_n = 1'b0;
      step(4);
      check_eq("R8", "clk_out in reset", int'(clk_out), 0);
      check_eq("R8", "ctl_out in reset", int'(ctl_out), 1);
      check_eq("R8", "done in reset", int'(done), 0);
      rst_n = 1'b1;
      step(2);
   endtask

   task automatic t_nominal(int p);
      int base = n_rise;
      int bad = 0;
      wait_rises(base + 5);
      for (int i = base + 1; i < base + 5; i++) begin
         if (rt(i) - rt(i - 1) != p) bad++;
         if (hwd(i - 1) != p - p / 2) bad++;
      end
      check_eq("R1", "nominal period/high-time mismatches", bad, 0);
      check_eq("R1", "nominal interval", rt(base + 4) - rt(base + 3), p);
      check_eq("R1", "nominal high ticks", hwd(base + 3), p - p / 2);
   endtask

   task automatic t_glitch(int p, int t, int tgt, int off, bit rearm_mid);
      int base, g, bad;
      pulse_period = CW'(t);
      ctl_offset   = CW'(off);
      target_cycle = YW'(tgt);
      step(1);
      arm_after_rise(base);
      step(1);
      check_eq("R4", "done cleared after accepted arm", int'(done), 0);
      check_eq("R5", "ctl_out idle after accepted arm", int'(ctl_out), 1);
      if (rearm_mid) begin
         // R7: a second arm while pending must not restart the count
         wait_rises(base + 2);
         arm = 1'b1;
         step(1);
         arm = 1'b0;
      end
      g = base + tgt;
      wait_rises(g + 5);
      bad = 0;
      for (int i = base; i <= g; i++)
         if (rt(i) - rt(i - 1) != p) bad++;
      check_eq(rearm_mid ? "R7" : "R3", "windows before glitch not nominal", bad, 0);
      check_eq("R2", "first short period", rt(g + 1) - rt(g), t);
      check_eq("R2", "second short period", rt(g + 2) - rt(g + 1), t);
      check_eq("R2", "first short high", hwd(g), t / 2);
      check_eq("R2", "second short high", hwd(g + 1), t / 2);
      check_eq("R2", "final high of glitch window", hwd(g + 2), p - p / 2 - 2 * t);
      check_eq("R3", "interval into next window", rt(g + 3) - rt(g + 2), p - 2 * t);
      check_eq("R4", "window after glitch is nominal", rt(g + 4) - rt(g + 3), p);
      check_eq("R1", "high ticks after glitch", hwd(g + 3), p - p / 2);
      check_eq("R5", "control edge vs first rise", ctl_fall_t - rt(g), off - p / 2);
      check_eq("R4", "done rise tick", done_t, rt(g + 2) + hwd(g + 2) - 1);
      check_eq("R4", "done held", int'(done), 1);
      check_eq("R5", "ctl_out held low", int'(ctl_out), 0);
   endtask

   task automatic t_ignored(int p, int t, int off, string why);
      int base, bad;
      int done0 = int'(done);
      int ctl0  = int'(ctl_out);
      pulse_period = CW'(t);
      ctl_offset   = CW'(off);
      target_cycle = YW'(0);
      step(1);
      arm_after_rise(base);
      wait_rises(base + 5);
      bad = 0;
      for (int i = base; i < base + 5; i++)
         if (rt(i) - rt(i - 1) != p || hwd(i - 1) != p - p / 2) bad++;
      check_eq("R6", {why, ": non-nominal windows"}, bad, 0);
      check_eq("R6", {why, ": done unchanged"}, int'(done), done0);
      check_eq("R6", {why, ": ctl_out unchanged"}, int'(ctl_out), ctl0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk_fast);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      finish_run();
   end

   initial begin
      t_reset(20);
      t_nominal(20);
      // R6 boundaries while done is still 0
      t_ignored(20, 5, 4, "P/2+2T equals P");
      t_ignored(20, 1, 4, "T below 2");
      t_ignored(20, 3, 20, "offset equals P");
      // R3/R5: control edge one tick before the rise
      t_glitch(20, 3, 2, 9, 1'b0);
      // R4: re-arm after done; edge after the rise
      t_glitch(20, 3, 0, 14, 1'b0);
      // R2 boundary: final high of one tick
      t_reset(21);
      t_glitch(21, 5, 1, 3, 1'b0);
      // R7: repeated arm while pending; edge coincident with the rise
      t_reset(12);
      t_glitch(12, 2, 5, 6, 1'b1);
      t_reset(32);
      t_nominal(32);
      t_glitch(32, 4, 0, 18, 1'b0);
      step(4);
      finish_run();
   end

endmodule